// File: doc/BRIEF.md
# Packet Checksum Generator and Checker with FIFO Policy

This block guards a byte-wide packet stream with a 16-bit cyclic checksum using the generator x^16 + x^12 + x^5 + 1. It has two independent paths. The transmit path forwards payload bytes and, when checking is enabled, follows them with the two checksum bytes. The receive path computes the checksum over an incoming packet and holds back the two trailing bytes, so that only payload reaches the receive FIFO. When the packet ends, the block publishes a verdict.

On a failed check, a policy input selects one of two actions. With auto-clear high, the FIFO is told to discard the packet and no interrupt is raised. With auto-clear low, the data is kept and only the payload-ready interrupt fires. A passing check sets the status bit and raises both interrupts. Auto-clear is normally tied high. When checking is disabled, both paths pass bytes through untouched.

Top module: `pkt_crc_guard`

## Requirements
- R1: With checking enabled, after the last payload byte the transmit output emits the 16-bit checksum as two extra bytes, high byte first, with the last marker on the low byte. The checksum uses generator 0x1021, a register preset to 0xFFFF at every packet start, each byte fed MSB first, and no final inversion.
- R2: Every transmit payload byte appears on the transmit output, unchanged and in order, one clock after it is accepted.
- R3: With checking enabled, every received byte except the final two is written to the FIFO in arrival order, and the final two are never written.
- R4: A receive packet whose trailing two bytes (high byte first) equal the checksum of the bytes before them sets crc_ok to 1 and pulses irq_crc_ok and irq_payload_ready for one cycle with no fifo_clear. These outputs appear two clocks after the last byte is accepted.
- R5: A failed check with auto-clear at 1 pulses fifo_clear for one cycle, raises no interrupt and leaves crc_ok at 0.
- R6: A failed check with auto-clear at 0 pulses only irq_payload_ready, with no fifo_clear, and leaves crc_ok at 0.
- R7: Because of the 0xFFFF preset, zero bytes added in front of a payload change the checksum. A packet carrying extra leading 0x00 bytes with the checksum of the shorter payload fails.
- R8: With checking disabled, transmit adds no bytes and marks the final payload byte as last. Receive forwards every byte to the FIFO and then pulses only irq_payload_ready, with crc_ok at 0.
- R9: crc_ok holds its value between packets and is cleared one clock after the first byte of the next packet is accepted.
- R10: With checking enabled, a receive packet of a single byte fails and writes nothing. A two-byte packet 0xFF 0xFF (empty payload) passes and writes nothing.
- R11: The enable and auto-clear inputs are sampled on a packet's first byte. Changing them during the packet does not alter that packet's handling.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_crc_en | input | 1 | Enables checksum append and check |
| cfg_autoclr | input | 1 | Selects discard-on-failure policy |
| tx_in_valid | input | 1 | Transmit payload byte valid |
| tx_in_data | input | 8 | Transmit payload byte |
| tx_in_last | input | 1 | Marks the final payload byte |
| tx_out_valid | output | 1 | Transmit output byte valid |
| tx_out_data | output | 8 | Payload or checksum byte |
| tx_out_last | output | 1 | Final byte of the outgoing packet |
| rx_in_valid | input | 1 | Received byte valid |
| rx_in_data | input | 8 | Received byte |
| rx_in_last | input | 1 | Marks the final received byte |
| fifo_wr_valid | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 8 | FIFO write byte |
| fifo_clear | output | 1 | One-cycle request to flush the packet |
| crc_ok | output | 1 | Status of the last completed check |
| irq_crc_ok | output | 1 | One-cycle checksum-good interrupt |
| irq_payload_ready | output | 1 | One-cycle payload-ready interrupt |

## Verification
A wrong checksum register value is visible in the first appended transmit byte, one clock after the last payload byte. On receive, the same error turns a good packet into a verdict of clear or payload-ready-only two clocks after the last byte. An off-by-one in the hold-back line shows up on the FIFO write strobe within the same packet: a checksum byte gets written, or the first payload byte is lost. A stale latched configuration surfaces as the wrong verdict kind at packet end. A status that is not cleared shows one clock after the next packet's first byte.

// File: rtl/pkt_crc_pkg.sv
package pkt_crc_pkg;
   typedef enum logic [2:0] {
      VERD_NONE       = 3'd0,
      VERD_PASS       = 3'd1,
      VERD_FAIL_CLEAR = 3'd2,
      VERD_FAIL_KEEP  = 3'd3,
      VERD_BYPASS     = 3'd4
   } verdict_e;
endpackage

// File: rtl/pkt_crc_step.sv
module pkt_crc_step #(
   parameter int               CRC_W     = 16,
   parameter int               DATA_W    = 8,
   parameter logic [CRC_W-1:0] POLY      = 16'h1021,
   parameter bit               MSB_FIRST = 1'b1
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  crc_out
);
   logic [CRC_W-1:0] poly_rev;

   for (genvar k = 0; k < CRC_W; k++) begin : g_rev
      assign poly_rev[k] = POLY[CRC_W-1-k];
   end

   if (MSB_FIRST) begin : g_msb
      always_comb begin
         logic [CRC_W-1:0] c;
         logic             fb;
         c = crc_in;
         for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ data_in[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ POLY;
         end
         crc_out = c;
      end
   end else begin : g_lsb
      always_comb begin
         logic [CRC_W-1:0] c;
         logic             fb;
         c = crc_in;
         for (int i = 0; i < DATA_W; i++) begin
            fb = c[0] ^ data_in[i];
            c  = {1'b0, c[CRC_W-1:1]};
            if (fb) c = c ^ poly_rev;
         end
         crc_out = c;
      end
   end
endmodule

// File: rtl/pkt_crc_tx.sv
module pkt_crc_tx #(
   parameter int               CRC_W     = 16,
   parameter int               DATA_W    = 8,
   parameter logic [CRC_W-1:0] POLY      = 16'h1021,
   parameter logic [CRC_W-1:0] PRESET    = 16'hFFFF,
   parameter bit               MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last
);
   localparam int NB = CRC_W / DATA_W;
   localparam int CW = $clog2(NB + 1);

   logic              in_pkt_q;
   logic              en_q;
   logic [CRC_W-1:0]  crc_q;
   logic [CW-1:0]     app_cnt_q;
   logic              en_eff;
   logic [CRC_W-1:0]  crc_base;
   logic [CRC_W-1:0]  crc_nxt;
   logic [DATA_W-1:0] emit_byte;
   logic [CRC_W-1:0]  crc_shifted;

   assign en_eff   = in_pkt_q ? en_q : cfg_en;
   assign crc_base = in_pkt_q ? crc_q : PRESET;

   pkt_crc_step #(
      .CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .MSB_FIRST(MSB_FIRST)
   ) u_step (
      .crc_in (crc_base),
      .data_in(in_data),
      .crc_out(crc_nxt)
   );

   if (MSB_FIRST) begin : g_emit_hi
      assign emit_byte   = crc_q[CRC_W-1 -: DATA_W];
      assign crc_shifted = crc_q << DATA_W;
   end else begin : g_emit_lo
      assign emit_byte   = crc_q[DATA_W-1:0];
      assign crc_shifted = crc_q >> DATA_W;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_pkt_q  <= 1'b0;
         en_q      <= 1'b0;
         crc_q     <= '0;
         app_cnt_q <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         if (in_valid) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
            out_last  <= in_last && !en_eff;
            crc_q     <= crc_nxt;
            in_pkt_q  <= !in_last;
            if (!in_pkt_q) en_q <= cfg_en;
            if (in_last && en_eff) app_cnt_q <= CW'(NB);
         end else if (app_cnt_q != '0) begin
            out_valid <= 1'b1;
            out_data  <= emit_byte;
            out_last  <= (app_cnt_q == CW'(1));
            crc_q     <= crc_shifted;
            app_cnt_q <= app_cnt_q - CW'(1);
         end
      end
   end

   // R1: the source leaves the output free while checksum bytes go out
   a_r1_no_input_during_append: assert property (@(posedge clk) disable iff (!rst_n)
      (app_cnt_q != '0) |-> !in_valid);

   // R2: every accepted byte leaves one clock later
   a_r2_pass_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: rtl/pkt_crc_rx.sv
module pkt_crc_rx
   import pkt_crc_pkg::*;
#(
   parameter int               CRC_W     = 16,
   parameter int               DATA_W    = 8,
   parameter logic [CRC_W-1:0] POLY      = 16'h1021,
   parameter logic [CRC_W-1:0] PRESET    = 16'hFFFF,
   parameter bit               MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_autoclr,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic              wr_valid,
   output logic [DATA_W-1:0] wr_data,
   output logic              pkt_start,
   output verdict_e          verd
);
   localparam int NB = CRC_W / DATA_W;
   localparam int FW = $clog2(NB + 1);

   logic              in_pkt_q;
   logic              en_q;
   logic              aclr_q;
   logic [FW-1:0]     fill_q;
   logic [CRC_W-1:0]  crc_q;
   logic [DATA_W-1:0] hold_q [NB];
   logic              en_eff;
   logic              aclr_eff;
   logic [FW-1:0]     fill_eff;
   logic [CRC_W-1:0]  crc_base;
   logic [CRC_W-1:0]  crc_nxt;
   logic              residue_ok;
   logic              long_enough;

   assign pkt_start   = in_valid && !in_pkt_q;
   assign en_eff      = pkt_start ? cfg_en      : en_q;
   assign aclr_eff    = pkt_start ? cfg_autoclr : aclr_q;
   assign fill_eff    = pkt_start ? '0          : fill_q;
   assign crc_base    = pkt_start ? PRESET      : crc_q;
   assign residue_ok  = (crc_nxt == '0);
   assign long_enough = (fill_eff >= FW'(NB - 1));

   pkt_crc_step #(
      .CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .MSB_FIRST(MSB_FIRST)
   ) u_step (
      .crc_in (crc_base),
      .data_in(in_data),
      .crc_out(crc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_pkt_q <= 1'b0;
         en_q     <= 1'b0;
         aclr_q   <= 1'b0;
         fill_q   <= '0;
         crc_q    <= '0;
         wr_valid <= 1'b0;
         wr_data  <= '0;
         verd     <= VERD_NONE;
         for (int k = 0; k < NB; k++) hold_q[k] <= '0;
      end else begin
         wr_valid <= 1'b0;
         verd     <= VERD_NONE;
         if (in_valid) begin
            in_pkt_q <= !in_last;
            crc_q    <= crc_nxt;
            if (pkt_start) begin
               en_q   <= cfg_en;
               aclr_q <= cfg_autoclr;
            end
            if (!en_eff) begin
               wr_valid <= 1'b1;
               wr_data  <= in_data;
            end else begin
               if (fill_eff == FW'(NB)) begin
                  wr_valid <= 1'b1;
                  wr_data  <= hold_q[NB-1];
               end
               hold_q[0] <= in_data;
               for (int k = 1; k < NB; k++) hold_q[k] <= hold_q[k-1];
               if (in_last)                   fill_q <= '0;
               else if (fill_eff == FW'(NB))  fill_q <= FW'(NB);
               else                           fill_q <= fill_eff + FW'(1);
            end
            if (in_last) begin
               if (!en_eff)                        verd <= VERD_BYPASS;
               else if (residue_ok && long_enough) verd <= VERD_PASS;
               else if (aclr_eff)                  verd <= VERD_FAIL_CLEAR;
               else                                verd <= VERD_FAIL_KEEP;
            end
         end
      end
   end

   // R3: a FIFO write only ever follows an accepted byte
   a_r3_write_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(in_valid));

   // R10: a verdict only follows a last marker
   a_r10_verdict_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      (verd != VERD_NONE) |-> $past(in_valid && in_last));
endmodule

// File: rtl/pkt_crc_verdict.sv
module pkt_crc_verdict
   import pkt_crc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pkt_start,
   input  verdict_e verd,
   output logic     crc_ok,
   output logic     fifo_clear,
   output logic     irq_crc_ok,
   output logic     irq_payload_ready
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_ok            <= 1'b0;
         fifo_clear        <= 1'b0;
         irq_crc_ok        <= 1'b0;
         irq_payload_ready <= 1'b0;
      end else begin
         fifo_clear        <= 1'b0;
         irq_crc_ok        <= 1'b0;
         irq_payload_ready <= 1'b0;
         case (verd)
            VERD_PASS: begin
               crc_ok            <= 1'b1;
               irq_crc_ok        <= 1'b1;
               irq_payload_ready <= 1'b1;
            end
            VERD_FAIL_CLEAR: begin
               crc_ok     <= 1'b0;
               fifo_clear <= 1'b1;
            end
            VERD_FAIL_KEEP, VERD_BYPASS: begin
               crc_ok            <= 1'b0;
               irq_payload_ready <= 1'b1;
            end
            default: begin
               if (pkt_start) crc_ok <= 1'b0;
            end
         endcase
      end
   end

   // R4: a good-checksum interrupt always comes with payload-ready and no flush
   a_r4_ok_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
      irq_crc_ok |-> (irq_payload_ready && !fifo_clear));

   // R5: a flush request is silent
   a_r5_clear_silent: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clear |-> (!irq_payload_ready && !irq_crc_ok && !crc_ok));

   // R9: status only rises together with the good-checksum interrupt
   a_r9_status_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_ok) |-> irq_crc_ok);
endmodule

// File: rtl/pkt_crc_guard.sv
module pkt_crc_guard
   import pkt_crc_pkg::*;
#(
   parameter int               CRC_W     = 16,
   parameter int               DATA_W    = 8,
   parameter logic [CRC_W-1:0] POLY      = 16'h1021,
   parameter logic [CRC_W-1:0] PRESET    = 16'hFFFF,
   parameter bit               MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_crc_en,
   input  logic              cfg_autoclr,
   input  logic              tx_in_valid,
   input  logic [DATA_W-1:0] tx_in_data,
   input  logic              tx_in_last,
   output logic              tx_out_valid,
   output logic [DATA_W-1:0] tx_out_data,
   output logic              tx_out_last,
   input  logic              rx_in_valid,
   input  logic [DATA_W-1:0] rx_in_data,
   input  logic              rx_in_last,
   output logic              fifo_wr_valid,
   output logic [DATA_W-1:0] fifo_wr_data,
   output logic              fifo_clear,
   output logic              crc_ok,
   output logic              irq_crc_ok,
   output logic              irq_payload_ready
);
   if (DATA_W < 1 || CRC_W < 2 * DATA_W) begin : g_bad_width
      $error("checksum must span at least two data words");
   end
   if (CRC_W % DATA_W != 0) begin : g_bad_ratio
      $error("checksum width must be a whole number of data words");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("generator must have a constant term");
   end

   logic     rx_start;
   verdict_e rx_verd;

   pkt_crc_tx #(
      .CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .PRESET(PRESET), .MSB_FIRST(MSB_FIRST)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_en   (cfg_crc_en),
      .in_valid (tx_in_valid),
      .in_data  (tx_in_data),
      .in_last  (tx_in_last),
      .out_valid(tx_out_valid),
      .out_data (tx_out_data),
      .out_last (tx_out_last)
   );

   pkt_crc_rx #(
      .CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .PRESET(PRESET), .MSB_FIRST(MSB_FIRST)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_en     (cfg_crc_en),
      .cfg_autoclr(cfg_autoclr),
      .in_valid   (rx_in_valid),
      .in_data    (rx_in_data),
      .in_last    (rx_in_last),
      .wr_valid   (fifo_wr_valid),
      .wr_data    (fifo_wr_data),
      .pkt_start  (rx_start),
      .verd       (rx_verd)
   );

   pkt_crc_verdict u_verdict (
      .clk              (clk),
      .rst_n            (rst_n),
      .pkt_start        (rx_start),
      .verd             (rx_verd),
      .crc_ok           (crc_ok),
      .fifo_clear       (fifo_clear),
      .irq_crc_ok       (irq_crc_ok),
      .irq_payload_ready(irq_payload_ready)
   );
endmodule

// File: tb/pkt_crc_guard_tb.sv
module pkt_crc_guard_tb;
   typedef logic [7:0] bq_t[$];

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_crc_en = 1'b0, cfg_autoclr = 1'b1;
   logic       tx_in_valid = 1'b0, tx_in_last = 1'b0;
   logic [7:0] tx_in_data = '0;
   logic       tx_out_valid, tx_out_last;
   logic [7:0] tx_out_data;
   logic       rx_in_valid = 1'b0, rx_in_last = 1'b0;
   logic [7:0] rx_in_data = '0;
   logic       fifo_wr_valid, fifo_clear, crc_ok, irq_crc_ok, irq_payload_ready;
   logic [7:0] fifo_wr_data;

   int checks = 0;
   int failures = 0;

   logic [8:0] tx_q[$];
   string      tx_tag[$];
   logic [7:0] rx_q[$];
   string      rx_tag[$];
   logic [3:0] ev_q[$];
   string      ev_tag[$];

   always #2 clk = ~clk;

   pkt_crc_guard u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_crc_en(cfg_crc_en), .cfg_autoclr(cfg_autoclr),
      .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data), .tx_in_last(tx_in_last),
      .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_last(tx_out_last),
      .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_last(rx_in_last),
      .fifo_wr_valid(fifo_wr_valid), .fifo_wr_data(fifo_wr_data), .fifo_clear(fifo_clear),
      .crc_ok(crc_ok), .irq_crc_ok(irq_crc_ok), .irq_payload_ready(irq_payload_ready)
   );

   task automatic check(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_crc(input bq_t d, input int n);
      logic [15:0] c = 16'hFFFF;
      for (int i = 0; i < n; i++) begin
         for (int b = 7; b >= 0; b--) begin
            logic fb;
            fb = c[15] ^ d[i][b];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
         end
      end
      return c;
   endfunction

   function automatic bq_t with_crc(input bq_t p);
      bq_t r = p;
      logic [15:0] c = ref_crc(p, p.size());
      r.push_back(c[15:8]);
      r.push_back(c[7:0]);
      return r;
   endfunction

   task automatic send_tx(input bq_t p, input bit en, input string tag);
      int n = p.size();
      logic [15:0] c = ref_crc(p, n);
      for (int i = 0; i < n; i++) begin
         tx_q.push_back({(i == n - 1) && !en, p[i]});
         tx_tag.push_back(tag);
      end
      if (en) begin
         tx_q.push_back({1'b0, c[15:8]}); tx_tag.push_back("R1");
         tx_q.push_back({1'b1, c[7:0]});  tx_tag.push_back("R1");
      end
      cfg_crc_en = en;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tx_in_valid = 1'b1; tx_in_data = p[i]; tx_in_last = (i == n - 1);
      end
      @(negedge clk);
      tx_in_valid = 1'b0; tx_in_last = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_rx(input bq_t p, input bit en, input bit aclr, input bit flip,
                          input string tag);
      int  n = p.size();
      bit  pass;
      int  npay;
      pass = en && n >= 2 && ref_crc(p, n - 2) == {p[n-2], p[n-1]};
      npay = en ? (n >= 2 ? n - 2 : 0) : n;
      for (int i = 0; i < npay; i++) begin
         rx_q.push_back(p[i]); rx_tag.push_back(tag);
      end
      if (!en)        ev_q.push_back(4'b0100);
      else if (pass)  ev_q.push_back(4'b0111);
      else if (aclr)  ev_q.push_back(4'b1000);
      else            ev_q.push_back(4'b0100);
      ev_tag.push_back(tag);
      cfg_crc_en = en; cfg_autoclr = aclr;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i == 1) check(crc_ok == 1'b0, "R9 status cleared by next packet", crc_ok, 0);
         if (flip && i == 1) begin
            cfg_crc_en = ~en; cfg_autoclr = ~aclr;
         end
         rx_in_valid = 1'b1; rx_in_data = p[i]; rx_in_last = (i == n - 1);
      end
      @(negedge clk);
      if (n == 1) check(crc_ok == 1'b0, "R9 status cleared by next packet", crc_ok, 0);
      rx_in_valid = 1'b0; rx_in_last = 1'b0;
      cfg_crc_en = en; cfg_autoclr = aclr;
      repeat (4) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_out_valid) begin
            if (tx_q.size() == 0) check(1'b0, "R1 R2 unexpected tx byte", tx_out_data, 0);
            else begin
               logic [8:0] e;
               string t;
               e = tx_q.pop_front(); t = tx_tag.pop_front();
               check({tx_out_last, tx_out_data} == e, t, {tx_out_last, tx_out_data}, e);
            end
         end
         if (fifo_wr_valid) begin
            if (rx_q.size() == 0) check(1'b0, "R3 unexpected FIFO write", fifo_wr_data, 0);
            else begin
               logic [7:0] e;
               string t;
               e = rx_q.pop_front(); t = rx_tag.pop_front();
               check(fifo_wr_data == e, t, fifo_wr_data, e);
            end
         end
         if (fifo_clear || irq_payload_ready || irq_crc_ok) begin
            logic [3:0] a;
            a = {fifo_clear, irq_payload_ready, irq_crc_ok, crc_ok};
            if (ev_q.size() == 0) check(1'b0, "R4 R5 R6 unexpected event", a, 0);
            else begin
               logic [3:0] e;
               string t;
               e = ev_q.pop_front(); t = ev_tag.pop_front();
               check(a == e, t, a, e);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      bq_t p;
      repeat (3) @(negedge clk);
      check({tx_out_valid, fifo_wr_valid, fifo_clear, crc_ok, irq_crc_ok, irq_payload_ready} == 6'b0,
            "R12 outputs during reset", 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({tx_out_valid, tx_out_last, tx_out_data} == 10'b0, "R12 tx idle after reset",
            {tx_out_valid, tx_out_last, tx_out_data}, 0);
      check({fifo_wr_valid, fifo_clear, crc_ok, irq_crc_ok, irq_payload_ready} == 5'b0,
            "R12 rx idle after reset", 0, 0);

      // transmit
      p = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
      check(ref_crc(p, 9) == 16'h29B1, "R1 reference vector", ref_crc(p, 9), 16'h29B1);
      send_tx(p, 1'b1, "R2 tx payload");
      send_tx('{8'hA5}, 1'b1, "R2 tx single byte");
      send_tx('{8'h00, 8'h00, 8'h00}, 1'b1, "R7 tx zero payload");
      send_tx('{8'h10, 8'hFE, 8'h7C}, 1'b0, "R8 tx disabled");

      // receive
      send_rx(with_crc('{8'h12, 8'h34, 8'h56, 8'h78}), 1'b1, 1'b1, 1'b0, "R4 rx good");
      repeat (5) @(negedge clk);
      check(crc_ok == 1'b1, "R9 status held", crc_ok, 1);
      p = with_crc('{8'hDE, 8'hAD, 8'hBE});
      p[1] = 8'hAC;
      send_rx(p, 1'b1, 1'b1, 1'b0, "R5 rx bad flush");
      send_rx(with_crc('{8'h01, 8'h02}), 1'b1, 1'b0, 1'b0, "R4 rx good keep policy");
      p = with_crc('{8'h55, 8'h66, 8'h77});
      p[4] = p[4] ^ 8'h01;
      send_rx(p, 1'b1, 1'b0, 1'b0, "R6 rx bad keep");
      p = with_crc('{8'h01});
      p.push_front(8'h00); p.push_front(8'h00);
      send_rx(p, 1'b1, 1'b1, 1'b0, "R7 leading zeros");
      send_rx('{8'h11, 8'h22, 8'h33, 8'h44}, 1'b0, 1'b1, 1'b0, "R8 rx disabled");
      send_rx(with_crc('{8'h09, 8'h08, 8'h07}), 1'b1, 1'b1, 1'b0, "R3 rx strip");
      send_rx('{8'h5A}, 1'b1, 1'b1, 1'b0, "R10 one byte");
      send_rx('{8'hFF, 8'hFF}, 1'b1, 1'b0, 1'b0, "R10 empty payload");
      p = with_crc('{8'hC3, 8'h3C, 8'h99});
      p[0] = 8'hC2;
      send_rx(p, 1'b1, 1'b1, 1'b1, "R11 config change mid packet");
      send_rx(with_crc('{8'h42, 8'h24}), 1'b1, 1'b0, 1'b1, "R11 config change good packet");

      repeat (8) @(negedge clk);
      check(tx_q.size() == 0, "R1 R2 tx items left", tx_q.size(), 0);
      check(rx_q.size() == 0, "R3 FIFO items left", rx_q.size(), 0);
      check(ev_q.size() == 0, "R4 R5 R6 events left", ev_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule